// File: doc/BRIEF.md
# Counter-Ramp and Tracking ADC Controller

This block is the digital half of a counter-type analog-to-digital converter. It drives a binary code into an external DAC and reads back a single comparator bit. That bit is high while the held analog input lies above the DAC output. The comparator, the DAC and the sample-and-hold stage are all outside the block.

There are two ways to convert. A ramp conversion starts from zero and climbs one code per clock while the comparator stays high. The code it stops at is the result, so a higher input takes more clocks. The input must be held steady for the whole ramp. In tracking mode an up/down counter steps toward the input on every clock: up while the comparator is high, down while it is low. The code and the result then follow a slowly moving input without restarting from zero.

The controller is built around three named states:
- `ST_IDLE` waits for a start pulse.
- `ST_RAMP` runs one single conversion.
- `ST_TRACK` follows the input continuously.

The transitions are:
- idle-to-ramp: start with the mode input low.
- idle-to-track: start with the mode input high.
- ramp-finish: comparator low or code at all ones; goes back to idle.
- track-exit: mode input dropped; goes back to idle.

Top module: `cramp_adc_ctrl`

## Requirements
- R1: While the synchronous active-high reset is sampled high, the next cycle shows code 0, result 0, done low and busy low.
- R2: A start pulse sampled in `ST_IDLE` clears the code to 0 and raises busy from the next cycle on. The mode input selects the state: 0 selects `ST_RAMP` and 1 selects `ST_TRACK`.
- R3: In `ST_RAMP` the code rises by exactly one on each clock at which the comparator bit is 1 and the code is below all ones.
- R4: In `ST_RAMP` a comparator bit of 0 ends the conversion. The code stops, the result takes that code, and done is high for one cycle while busy drops. For an input level L below all ones, done appears L+1 clocks after the start edge.
- R5: A ramp whose comparator is still 1 at all ones ends with result all ones (2^CODE_W-1) and never wraps to 0. Done is then due 2^CODE_W clocks after the start edge.
- R6: In ramp mode the result changes only at the end of a conversion. In `ST_IDLE` without start, the code and the result hold. A start pulse while busy is ignored and leaves the conversion time unchanged.
- R7: In `ST_TRACK` each clock steps the code up by one if the comparator bit is 1 and down by one if it is 0. The result equals the new code after every clock.
- R8: In `ST_TRACK` the code holds at all ones while the comparator is 1 and holds at 0 while the comparator is 0. It never wraps.
- R9: In `ST_TRACK` done pulses for one cycle after a clock at which the comparator bit is 0 but was 1 at the previous tracking clock. Done is never high on two consecutive cycles.
- R10: Dropping the mode input in `ST_TRACK` returns the block to `ST_IDLE` at the next clock, with busy low and the code and result held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse, sampled in idle only |
| track_mode_i | input | 1 | 0 = single ramp, 1 = continuous tracking |
| cmp_above_i | input | 1 | Comparator: 1 when held input is above the DAC output |
| dac_code_o | output | CODE_W | Code driven into the external DAC |
| result_o | output | CODE_W | Latched conversion result |
| done_o | output | 1 | One-cycle completion / crossing strobe |
| busy_o | output | 1 | High while ramping or tracking |

## Verification
The bench runs the block with a 4-bit code, which makes every level from 0 to past full scale cheap to sweep. Its comparator is an ideal integer comparison against the live code.

A ramp result, and the done and busy change that goes with it, is due L+1 clocks after the start edge. The bench counts clocks from that edge and compares the count with the arithmetic value. In tracking mode every code and result step, and every done pulse, is due one clock after the comparator sample that caused it. The bench steps a small arithmetic model in lockstep with the clock and compares each cycle.

Inputs are driven and outputs sampled at the falling edge. Each comparison therefore sees exactly the registers updated by the rising edge just before it.

// File: rtl/cramp_pkg.sv
package cramp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RAMP  = 2'd1,
        ST_TRACK = 2'd2
    } cramp_state_e;

    typedef enum logic [1:0] {
        STEP_HOLD  = 2'd0,
        STEP_UP    = 2'd1,
        STEP_DOWN  = 2'd2,
        STEP_CLEAR = 2'd3
    } cramp_step_e;

endpackage

// File: rtl/cramp_updown.sv
module cramp_updown
    import cramp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  cramp_step_e step_i,
    output logic [W-1:0] count_o,
    output logic [W-1:0] count_nxt_o,
    output logic        at_max_o
);
    localparam logic [W-1:0] TOP  = {W{1'b1}};
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] count_q;
    logic [W-1:0] count_d;
    logic         at_zero;

    assign at_zero  = (count_q == ZERO);
    assign at_max_o = (count_q == TOP);

    // saturating step: never wraps at either end
    always_comb begin
        count_d = count_q;
        unique case (step_i)
            STEP_UP:    if (!at_max_o) count_d = count_q + ONE;
            STEP_DOWN:  if (!at_zero)  count_d = count_q - ONE;
            STEP_CLEAR: count_d = ZERO;
            STEP_HOLD:  count_d = count_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= ZERO;
        else     count_q <= count_d;
    end

    assign count_o     = count_q;
    assign count_nxt_o = count_d;
endmodule

// File: rtl/cramp_hold_reg.sv
module cramp_hold_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (load_i) q <= d_i;
    end

    assign q_o = q;
endmodule

// File: rtl/cramp_seq.sv
module cramp_seq
    import cramp_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         track_req_i,
    input  logic         cmp_above_i,
    input  logic         at_max_i,
    output cramp_state_e state_o,
    output cramp_step_e  step_o,
    output logic         load_o,
    output logic         done_o,
    output logic         busy_o
);
    cramp_state_e state, state_nxt;
    cramp_step_e  step;
    logic         finish, crossed, load;
    logic         cmp_q, seen_q, done_q;

    // next-state and step decision
    always_comb begin
        state_nxt = state;
        step      = STEP_HOLD;
        finish    = 1'b0;
        crossed   = 1'b0;
        load      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start_i) begin
                    step      = STEP_CLEAR;
                    state_nxt = track_req_i ? ST_TRACK : ST_RAMP;
                end
            end
            ST_RAMP: begin
                if (!cmp_above_i || at_max_i) begin
                    finish    = 1'b1;
                    load      = 1'b1;
                    state_nxt = ST_IDLE;
                end else begin
                    step = STEP_UP;
                end
            end
            ST_TRACK: begin
                if (!track_req_i) begin
                    state_nxt = ST_IDLE;
                end else begin
                    step    = cmp_above_i ? STEP_UP : STEP_DOWN;
                    load    = 1'b1;
                    crossed = seen_q && cmp_q && !cmp_above_i;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    // registered outputs and comparator history
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            cmp_q  <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            done_q <= finish | crossed;
            if (state == ST_TRACK && track_req_i) begin
                cmp_q  <= cmp_above_i;
                seen_q <= 1'b1;
            end else begin
                seen_q <= 1'b0;
            end
        end
    end

    assign state_o = state;
    assign step_o  = step;
    assign load_o  = load;
    assign done_o  = done_q;
    assign busy_o  = (state != ST_IDLE);
endmodule

// File: rtl/cramp_adc_ctrl.sv
module cramp_adc_ctrl
    import cramp_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              track_mode_i,
    input  logic              cmp_above_i,
    output logic [CODE_W-1:0] dac_code_o,
    output logic [CODE_W-1:0] result_o,
    output logic              done_o,
    output logic              busy_o
);
    cramp_state_e      st;
    cramp_step_e       step;
    logic              at_max;
    logic              load;
    logic [CODE_W-1:0] code, code_nxt;

    cramp_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .track_req_i (track_mode_i),
        .cmp_above_i (cmp_above_i),
        .at_max_i    (at_max),
        .state_o     (st),
        .step_o      (step),
        .load_o      (load),
        .done_o      (done_o),
        .busy_o      (busy_o)
    );

    cramp_updown #(.W(CODE_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .step_i      (step),
        .count_o     (code),
        .count_nxt_o (code_nxt),
        .at_max_o    (at_max)
    );

    cramp_hold_reg #(.W(CODE_W)) u_res (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .d_i    (code_nxt),
        .q_o    (result_o)
    );

    assign dac_code_o = code;
endmodule

// File: rtl/cramp_adc_chk.sv
module cramp_adc_chk
    import cramp_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic         track_mode_i,
    input logic         cmp_above_i,
    input logic [W-1:0] dac_code_o,
    input logic [W-1:0] result_o,
    input logic         done_o,
    input logic         busy_o,
    input cramp_state_e state
);
    localparam logic [W-1:0] TOP  = {W{1'b1}};
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W:0]   ONEX = (W+1)'(1);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (dac_code_o == '0 && result_o == '0 && !done_o && !busy_o)); // R1

    AST_RAMP_CLIMB: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RAMP && cmp_above_i && dac_code_o != TOP) |=> dac_code_o == $past(dac_code_o) + ONE); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (busy_o && dac_code_o == TOP && cmp_above_i) |=> dac_code_o == TOP); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> ($stable(dac_code_o) && $stable(result_o))); // R6

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> ({1'b0, dac_code_o} == {1'b0, $past(dac_code_o)}
                 || {1'b0, dac_code_o} == {1'b0, $past(dac_code_o)} + ONEX
                 || {1'b0, dac_code_o} + ONEX == {1'b0, $past(dac_code_o)})); // R7

    AST_TRACK_RESULT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TRACK && track_mode_i) |=> result_o == dac_code_o); // R7

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (busy_o && dac_code_o == '0 && !cmp_above_i) |=> dac_code_o == '0); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R9

    AST_TRACK_EXIT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TRACK && !track_mode_i) |=> (!busy_o && $stable(dac_code_o))); // R10
endmodule

bind cramp_adc_ctrl cramp_adc_chk #(.W(CODE_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .track_mode_i (track_mode_i),
    .cmp_above_i  (cmp_above_i),
    .dac_code_o   (dac_code_o),
    .result_o     (result_o),
    .done_o       (done_o),
    .busy_o       (busy_o),
    .state        (st)
);

// File: tb/cramp_adc_ctrl_test.sv
`timescale 1ns/1ps
module cramp_adc_ctrl_test;
    localparam int W    = 4;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         track = 1'b0;
    logic         cmp;
    logic [W-1:0] dac, res;
    logic         done, busy;

    int level = 0;
    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    int mcount = 0;
    bit mprev  = 1'b0;
    bit mvalid = 1'b0;

    always #2 clk = ~clk;

    // ideal DAC plus comparator
    assign cmp = (level > int'(dac));

    cramp_adc_ctrl #(.CODE_W(W)) uut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start),
        .track_mode_i (track),
        .cmp_above_i  (cmp),
        .dac_code_o   (dac),
        .result_o     (res),
        .done_o       (done),
        .busy_o       (busy)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic ramp(int lvl, bit poke);
        int exp_code;
        int n;
        level = lvl;
        track = 1'b0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R2 busy after start", int'(busy), 1);
        chk("R2 code cleared", int'(dac), 0);
        exp_code = (lvl < MAXV) ? lvl : MAXV;
        n = 0;
        while (n < 4 * (MAXV + 2)) begin
            @(negedge clk);
            n++;
            start = poke && (n == 3);
            if (done) break;
        end
        start = 1'b0;
        if (lvl >= MAXV) chk("R5 saturated latency", n, MAXV + 1);
        else             chk("R4 ramp latency", n, exp_code + 1);
        if (lvl >= MAXV) chk("R5 saturated result", int'(res), MAXV);
        else             chk("R4 ramp result", int'(res), exp_code);
        chk("R3 code at stop", int'(dac), exp_code);
        chk("R4 busy dropped", int'(busy), 0);
        @(negedge clk);
        chk("R4 done one cycle", int'(done), 0);
        level = (lvl + 7) % (MAXV + 3);
        @(negedge clk);
        chk("R6 idle result held", int'(res), exp_code);
        chk("R6 idle code held", int'(dac), exp_code);
    endtask

    task automatic track_begin();
        track = 1'b1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        mcount = 0;
        mvalid = 1'b0;
        chk("R2 track busy", int'(busy), 1);
        chk("R7 track cleared", int'(dac), 0);
    endtask

    task automatic track_run(int lvl, int cycles, string tag);
        for (int i = 0; i < cycles; i++) begin
            bit c;
            bit exp_done;
            level = lvl;
            c = (lvl > mcount);
            exp_done = mvalid && mprev && !c;
            if (c && mcount < MAXV) mcount++;
            else if (!c && mcount > 0) mcount--;
            mprev = c;
            mvalid = 1'b1;
            @(negedge clk);
            chk(tag, int'(dac), mcount);
            chk("R7 result follows", int'(res), mcount);
            chk("R9 crossing strobe", int'(done), int'(exp_done));
        end
    endtask

    initial begin
        for (int k = 0; k < 200000; k++) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset code", int'(dac), 0);
        chk("R1 reset result", int'(res), 0);
        chk("R1 reset done", int'(done), 0);
        chk("R1 reset busy", int'(busy), 0);
        rst = 1'b0;
        @(negedge clk);

        for (int l = 0; l <= MAXV + 3; l++) ramp(l, 1'b0);
        ramp(10, 1'b1);
        ramp(0, 1'b1);

        track_begin();
        track_run(9, 20, "R7 track up to level");
        track_run(12, 10, "R7 track rising input");
        track_run(3, 15, "R7 track falling input");
        track_run(0, 8, "R8 hold at zero");
        track_run(MAXV + 10, MAXV + 8, "R8 hold at full scale");
        track_run(6, 14, "R7 track back down");

        track = 1'b0;
        @(negedge clk);
        chk("R10 exit busy", int'(busy), 0);
        chk("R10 exit code", int'(dac), mcount);
        level = 2;
        repeat (3) @(negedge clk);
        chk("R10 code held", int'(dac), mcount);
        chk("R10 result held", int'(res), mcount);

        ramp(5, 1'b0);
        summary();
    end
endmodule